// File: doc/BRIEF.md
# Not-Recently-Used Replacement Victim Picker

This block tracks, for every physical frame of a paged memory, whether the frame has been touched recently and whether it holds data changed since it was loaded. Memory accesses report their frame index and whether they are writes. A periodic tick forgets recent use, while a load event marks a frame as freshly filled and clean. When the paging logic needs a frame to evict, it raises a request. One cycle later the block returns a frame index and that frame's class.

Each frame falls into one of four classes, formed from its two bits. The victim always comes from the lowest-numbered class that has at least one frame in it. Ties inside that class are not broken by index order. A free-running linear feedback shift register sets the starting point of a rotating search, so repeated requests against an unchanged state spread over the members of the class.

Top module: `nru_victim`

## Requirements
- R1: After a synchronous reset every frame has both its referenced and modified bits clear, so it is in class 0, and `vic_valid` is low.
- R2: An access to frame f sets f's referenced bit. A write access also sets f's modified bit. A read access leaves the modified bit unchanged.
- R3: The class of a frame is the 2-bit value {referenced, modified}: 0 means neither bit is set, 1 means modified only, 2 means referenced only, and 3 means both are set. `vic_class` reports this value for the frame in `vic_frame`.
- R4: A tick clears every referenced bit in the same cycle and leaves all modified bits unchanged. An access or load in the tick cycle is applied after the clear, so its frame ends up referenced.
- R5: A load of frame f sets f's referenced bit and clears its modified bit. A load takes precedence over an access to the same frame in the same cycle.
- R6: The returned frame is a member of the lowest-numbered class that is not empty, taken from the state before the request cycle's updates.
- R7: Inside the winning class the choice is not fixed. Repeated requests against a state that does not change return more than one distinct member when the class has two or more members.
- R8: `vic_valid` is high in exactly the cycle after each cycle in which `vic_req` is high, and low in every other cycle.
- R9: An access, tick or load in one cycle affects a request made in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | Access is a write |
| acc_frame | input | IDX_W | Frame index of the access |
| tick | input | 1 | Clear all referenced bits |
| load_valid | input | 1 | A new page is loaded into a frame |
| load_frame | input | IDX_W | Frame index of the load |
| vic_req | input | 1 | Victim request |
| vic_valid | output | 1 | Victim result valid, one cycle after the request |
| vic_frame | output | IDX_W | Chosen victim frame |
| vic_class | output | 2 | Class of the chosen frame |

## Verification
The hardest situations to reach are the ones where the answer is fully determined. One is a class that holds exactly one frame while every lower class is empty. The other is the same state held still long enough to see the random tie-break move. The stimulus first writes every frame and ticks, which moves every frame to class 1. It then reloads all frames but one, which leaves a single class-1 member that must be returned.

A separate phase issues a long run of requests from the reset state with no other activity, and collects the set of frames returned. Same-cycle tick-plus-access and load-plus-access collisions are driven both directly and inside a random phase. That phase compares every result against a reference model of the two bit arrays.

// File: rtl/nru_pkg.sv
// Package: shared class type and helpers for the victim picker.
// Assumes the frame count is a power of two of at least two.
package nru_pkg;
    typedef logic [1:0] nru_class_t;
    localparam int NUM_CLASSES = 4;

    // Returns the lowest class whose non-empty flag is set.
    function automatic nru_class_t lowest_class(input logic [NUM_CLASSES-1:0] nonempty);
        nru_class_t c;
        c = 2'd3;
        for (int i = NUM_CLASSES - 1; i >= 0; i--) begin
            if (nonempty[i]) c = nru_class_t'(i);
        end
        return c;
    endfunction
endpackage

// File: rtl/nru_lfsr.sv
// Module: free-running Galois LFSR supplying the start offset for searches.
// Assumes SEED is non-zero and IDX_W <= LFSR_W.
module nru_lfsr #(
    parameter int          LFSR_W = 16,
    parameter int          IDX_W  = 3,
    parameter logic [15:0] TAPS   = 16'hB400,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] offset
);
    logic [LFSR_W-1:0] lfsr_q;

    // Shifts the register each cycle, folding in the taps when the low bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED[LFSR_W-1:0];
        else if (lfsr_q[0]) lfsr_q <= (lfsr_q >> 1) ^ TAPS[LFSR_W-1:0];
        else lfsr_q <= lfsr_q >> 1;
    end

    // Exposes the low bits as the search offset.
    assign offset = lfsr_q[IDX_W-1:0];

    // R7: the generator must never lock up at zero.
    a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: rtl/nru_state.sv
// Module: per-frame referenced and modified bits.
// Order within one cycle: a tick clears, then an access applies, then a load applies.
module nru_state #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [IDX_W-1:0] acc_frame,
    input  logic             tick,
    input  logic             load_valid,
    input  logic [IDX_W-1:0] load_frame,
    output logic [N-1:0]     ref_q,
    output logic [N-1:0]     mod_q
);
    logic [N-1:0] ref_d;
    logic [N-1:0] mod_d;

    // Computes the next bit vectors in the priority order tick, access, load.
    always_comb begin
        ref_d = tick ? '0 : ref_q;
        mod_d = mod_q;
        if (acc_valid) begin
            ref_d[acc_frame] = 1'b1;
            if (acc_write) mod_d[acc_frame] = 1'b1;
        end
        if (load_valid) begin
            ref_d[load_frame] = 1'b1;
            mod_d[load_frame] = 1'b0;
        end
    end

    // Registers the bit vectors, clearing them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
            mod_q <= '0;
        end else begin
            ref_q <= ref_d;
            mod_q <= mod_d;
        end
    end

    // R2: an access leaves its frame referenced.
    a_r2_access_sets_ref: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ref_q[$past(acc_frame)]);
    // R2: a write without a load on the same frame leaves it modified.
    a_r2_write_sets_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !(load_valid && load_frame == acc_frame))
        |=> mod_q[$past(acc_frame)]);
    // R4: a lone tick clears all referenced bits.
    a_r4_tick_clears_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !acc_valid && !load_valid) |=> ref_q == '0);
    // R4: a lone tick keeps the modified bits.
    a_r4_tick_keeps_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !acc_valid && !load_valid) |=> mod_q == $past(mod_q));
    // R5: a load leaves its frame referenced and clean.
    a_r5_load_clean: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> (ref_q[$past(load_frame)] && !mod_q[$past(load_frame)]));
endmodule

// File: rtl/nru_rot_pick.sv
// Module: rotating priority pick. Finds the first set bit of the mask
// starting at the offset and wrapping. Assumes N is a power of two.
module nru_rot_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     mask,
    input  logic [IDX_W-1:0] offset,
    output logic             any,
    output logic [IDX_W-1:0] pick
);
    logic [2*N-1:0]   doubled;
    logic [N-1:0]     rotated;
    logic [IDX_W-1:0] rel;

    // Rotates the mask so that the offset position comes first.
    always_comb begin
        doubled = {mask, mask} >> offset;
        rotated = doubled[N-1:0];
    end

    // Finds the lowest set bit of the rotated mask.
    always_comb begin
        rel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (rotated[i]) rel = IDX_W'(i);
        end
    end

    // Maps the position back to a frame index and flags an empty mask.
    assign pick = rel + offset;
    assign any  = |mask;

    // R6: a non-empty mask always yields one of its own members.
    always_comb begin
        if (any) begin
            a_r6_pick_in_class: assert (mask[pick]);
        end
    end
endmodule

// File: rtl/nru_victim.sv
// Module: top of the not-recently-used victim picker. It sorts frames into
// four classes from their referenced and modified bits. It runs one rotating
// search per class and registers the winner of the lowest non-empty class.
// Assumes N is a power of two of at least two.
module nru_victim
    import nru_pkg::*;
#(
    parameter int N      = 8,
    parameter int LFSR_W = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [IDX_W-1:0] acc_frame,
    input  logic             tick,
    input  logic             load_valid,
    input  logic [IDX_W-1:0] load_frame,
    input  logic             vic_req,
    output logic             vic_valid,
    output logic [IDX_W-1:0] vic_frame,
    output logic [1:0]       vic_class
);
    logic [N-1:0]             ref_q;
    logic [N-1:0]             mod_q;
    logic [IDX_W-1:0]         offset;
    logic [N-1:0]             cls_mask [NUM_CLASSES];
    logic [NUM_CLASSES-1:0]   cls_any;
    logic [IDX_W-1:0]         cls_pick [NUM_CLASSES];
    nru_class_t               win_cls;

    nru_state #(.N(N), .IDX_W(IDX_W)) i_state (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_frame(acc_frame),
        .tick(tick), .load_valid(load_valid), .load_frame(load_frame),
        .ref_q(ref_q), .mod_q(mod_q)
    );

    nru_lfsr #(.LFSR_W(LFSR_W), .IDX_W(IDX_W)) i_lfsr (
        .clk(clk), .rst_n(rst_n), .offset(offset)
    );

    // One class-membership mask and one rotating search for each class.
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        for (genvar f = 0; f < N; f++) begin : g_frm
            assign cls_mask[c][f] = ({ref_q[f], mod_q[f]} == 2'(c));
        end
        nru_rot_pick #(.N(N), .IDX_W(IDX_W)) i_pick (
            .mask(cls_mask[c]), .offset(offset),
            .any(cls_any[c]), .pick(cls_pick[c])
        );
    end

    // Chooses the lowest class that has a member.
    assign win_cls = lowest_class(cls_any);

    // Registers the result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vic_valid <= 1'b0;
            vic_frame <= '0;
            vic_class <= '0;
        end else begin
            vic_valid <= vic_req;
            if (vic_req) begin
                vic_frame <= cls_pick[win_cls];
                vic_class <= win_cls;
            end
        end
    end

    // R6: no class below the winner has a member.
    always_comb begin
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (c < int'(win_cls)) begin
                a_r6_lower_empty: assert (!cls_any[c]);
            end
        end
    end
    // R8: a request is answered in the next cycle.
    a_r8_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        vic_req |=> vic_valid);
    // R8: no result appears without a request.
    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !vic_req |=> !vic_valid);
endmodule

// File: tb/test_nru_victim.sv
// Bench: reference model of the bit arrays, directed corner cases, then seeded random traffic.
module test_nru_victim;
    localparam int N     = 8;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             acc_valid, acc_write, tick, load_valid, vic_req;
    logic [IDX_W-1:0] acc_frame, load_frame;
    logic             vic_valid;
    logic [IDX_W-1:0] vic_frame;
    logic [1:0]       vic_class;

    int checks = 0;
    int fails  = 0;
    logic [N-1:0] ref_m, mod_m;
    logic [N-1:0] snap_ref, snap_mod;
    logic [N-1:0] seen;

    always #10 clk = ~clk;

    nru_victim #(.N(N)) i_nru_victim (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_frame(acc_frame),
        .tick(tick), .load_valid(load_valid), .load_frame(load_frame),
        .vic_req(vic_req), .vic_valid(vic_valid),
        .vic_frame(vic_frame), .vic_class(vic_class)
    );

    function automatic logic [1:0] exp_lowest(input logic [N-1:0] r, input logic [N-1:0] m);
        logic [1:0] best;
        best = 2'd3;
        for (int f = 0; f < N; f++) begin
            if ({r[f], m[f]} < best) best = {r[f], m[f]};
        end
        return best;
    endfunction

    task automatic check(input string tag, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Runs one cycle from a negedge and checks the outputs at the next negedge.
    task automatic cyc(input logic av, input logic wr, input int af, input logic tk,
                       input logic lv, input int lf, input logic rq, input string tag);
        acc_valid = av; acc_write = wr; acc_frame = IDX_W'(af);
        tick = tk; load_valid = lv; load_frame = IDX_W'(lf); vic_req = rq;
        snap_ref = ref_m; snap_mod = mod_m;
        if (tk) ref_m = '0;
        if (av) begin
            ref_m[af] = 1'b1;
            if (wr) mod_m[af] = 1'b1;
        end
        if (lv) begin
            ref_m[lf] = 1'b1;
            mod_m[lf] = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " R8 valid"}, vic_valid == rq, int'(vic_valid), int'(rq));
        if (rq && vic_valid) begin
            check({tag, " R6 lowest class"}, vic_class == exp_lowest(snap_ref, snap_mod),
                  int'(vic_class), int'(exp_lowest(snap_ref, snap_mod)));
            check({tag, " R3 class of frame"},
                  vic_class == {snap_ref[vic_frame], snap_mod[vic_frame]},
                  int'(vic_class), int'({snap_ref[vic_frame], snap_mod[vic_frame]}));
        end
    endtask

    task automatic idle_req(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 1, tag);
    endtask

    initial begin
        void'($urandom(32'd4711));
        acc_valid = 0; acc_write = 0; acc_frame = '0; tick = 0;
        load_valid = 0; load_frame = '0; vic_req = 0;
        ref_m = '0; mod_m = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: after reset there is no result and every frame is in class 0.
        check("R1 valid low", vic_valid == 1'b0, int'(vic_valid), 0);
        idle_req("R1");
        check("R1 class 0", vic_class == 2'd0, int'(vic_class), 0);

        // R7: with the state frozen, repeated requests spread over the class.
        seen = '0;
        for (int k = 0; k < 32; k++) begin
            idle_req("R7");
            seen[vic_frame] = 1'b1;
        end
        check("R7 distinct picks", $countones(seen) > 1, $countones(seen), 2);

        // R2: reads make every frame class 2.
        for (int f = 0; f < N; f++) cyc(1, 0, f, 0, 0, 0, 0, "R2 read");
        idle_req("R2 read");
        check("R2 all read class", vic_class == 2'd2, int'(vic_class), 2);
        // R2: writes make every frame class 3.
        for (int f = 0; f < N; f++) cyc(1, 1, f, 0, 0, 0, 0, "R2 write");
        idle_req("R2 write");
        check("R2 all written class", vic_class == 2'd3, int'(vic_class), 3);
        // R4: a tick keeps the modified bits, so every frame is now class 1.
        cyc(0, 0, 0, 1, 0, 0, 0, "R4 tick");
        idle_req("R4 tick");
        check("R4 class after tick", vic_class == 2'd1, int'(vic_class), 1);
        // R5: reloading all frames but 6 leaves frame 6 as the only class-1 member.
        for (int f = 0; f < N; f++) if (f != 6) cyc(0, 0, 0, 0, 1, f, 0, "R5 load");
        idle_req("R5 single");
        check("R5 single member frame", vic_frame == 3'd6, int'(vic_frame), 6);
        check("R5 single member class", vic_class == 2'd1, int'(vic_class), 1);
        // R4: a read of frame 6 in the tick cycle leaves it referenced, so frame 6 is class 3.
        cyc(1, 0, 6, 1, 0, 0, 0, "R4 tick+acc");
        for (int f = 0; f < N; f++) if (f != 6) cyc(1, 1, f, 0, 1, f, 0, "R5 load+write");
        // R5: the loads override the same-cycle writes, so the other frames are class 2.
        idle_req("R5 precedence");
        check("R5 load over write", vic_class == 2'd2, int'(vic_class), 2);
        check("R4 frame 6 not picked", vic_frame != 3'd6, int'(vic_frame), 6);
        // R9: a write in one cycle is visible to a request in the next cycle.
        cyc(1, 1, 3, 0, 0, 0, 0, "R9");
        idle_req("R9 next");
        check("R9 frame 3 skipped", vic_frame != 3'd3, int'(vic_frame), 3);

        // Random traffic checked against the model.
        for (int k = 0; k < 3000; k++) begin
            cyc(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)),
                int'($urandom_range(0, N - 1)), ($urandom_range(0, 15) == 0),
                ($urandom_range(0, 5) == 0), int'($urandom_range(0, N - 1)),
                logic'($urandom_range(0, 1)), "random");
        end
        cyc(0, 0, 0, 0, 0, 0, 0, "R8 idle");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule